// File: doc/BRIEF.md
# Tagged Half-Word Test Unit

This unit sits between the load path and the execute stage of a small processor. Each memory half-word arrives as 24 data bits with a 3-bit tag beside it. The unit passes both through unchanged. Software loads a 3-bit reference tag into the unit. Any instruction may ask for a tag test on the half-word it fetched.

A test runs in one of two modes. Match mode requires the fetched tag to equal the reference. Differ mode requires the two to be different. The tag bits carry no meaning inside the unit: it only compares them and never reads the data according to the tag.

When a requested test fails, the unit sets a sticky fault flag and records the offending tag and the mode that was used, so that a handler can read them. The interrupt request is the fault flag gated by a software-writable enable bit. The flag stays set until software pulses an explicit clear input.

Top module: `tagchk_unit`

## Requirements
- R1: `data_out` equals `mem_data` and `tag_out` equals `mem_tag` in the same cycle, whatever the tag or test inputs are.
- R2: In match mode (`test_mode`=0), a cycle with `test_req`=1 and `mem_valid`=1 in which `mem_tag` differs from `ref_tag` sets `tag_fault` at the next clock edge.
- R3: In differ mode (`test_mode`=1), a cycle with `test_req`=1 and `mem_valid`=1 in which `mem_tag` equals `ref_tag` sets `tag_fault` at the next clock edge.
- R4: Once set, `tag_fault` stays set until a cycle with `fault_clear`=1 and no failing test. Such a cycle clears it at the next edge.
- R5: A cycle with `test_req`=0 or `mem_valid`=0 never sets `tag_fault`, even when the tags would fail either test.
- R6: `irq` is 1 exactly when `tag_fault`=1 and `irq_enable`=1. `irq_enable` loads `irq_en_wdata` at the edge where `irq_en_wr`=1.
- R7: A failing test that occurs while `tag_fault` is clear records the fetched tag in `cap_tag` and the mode in `cap_mode` (0 = match, 1 = differ). Later failures do not change `cap_tag` or `cap_mode` while the flag stays set.
- R8: `ref_tag` loads `tag_wr_data` at the edge where `tag_wr_en`=1. A test in that same cycle compares against the old value.
- R9: While `rst_n`=0, `ref_tag`, `tag_fault`, `cap_tag`, `cap_mode`, `irq_enable` and `irq` are all 0.
- R10: If `fault_clear` and a failing test occur in the same cycle, `tag_fault` is 1 after the edge, and the capture takes the new failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_wr_en | input | 1 | Load the reference tag |
| tag_wr_data | input | 3 | New reference tag |
| irq_en_wr | input | 1 | Load the interrupt enable |
| irq_en_wdata | input | 1 | New interrupt enable |
| test_req | input | 1 | Instruction requests a tag test |
| test_mode | input | 1 | 0 = tags must match, 1 = tags must differ |
| mem_valid | input | 1 | Fetched half-word is valid |
| mem_data | input | 24 | Fetched data bits |
| mem_tag | input | 3 | Fetched tag bits |
| fault_clear | input | 1 | Clear the fault flag |
| data_out | output | 24 | Data passed through to execute |
| tag_out | output | 3 | Tag passed through to execute |
| ref_tag | output | 3 | Current reference tag |
| irq_enable | output | 1 | Current interrupt enable |
| tag_fault | output | 1 | Sticky fault flag |
| cap_tag | output | 3 | Tag of the first failing half-word |
| cap_mode | output | 1 | Mode of the first failing test |
| irq | output | 1 | Maskable interrupt request |

## Verification
The bound assertions check the following on every cycle:
- a failing test in either mode is followed by a set flag;
- the flag never rises without a valid requested test;
- the flag holds until a clear;
- the capture stays still while the flag is set;
- the interrupt is low whenever the enable is low.

Some behaviours only the bench scenarios can show. These are the exact captured values after a run of failures, the old-versus-new reference tag when a write and a test share a cycle, and the clear-versus-set collision.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
  localparam int unsigned DATA_W = 24;
  localparam int unsigned TAG_W  = 3;

  typedef enum logic {
    MODE_MATCH  = 1'b0,
    MODE_DIFFER = 1'b1
  } tag_mode_e;
endpackage

// File: rtl/tagchk_ref_reg.sv
module tagchk_ref_reg #(
  parameter int unsigned TAG_W = tagchk_pkg::TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_wr_en,
  input  logic [TAG_W-1:0] tag_wr_data,
  input  logic             en_wr,
  input  logic             en_wdata,
  output logic [TAG_W-1:0] ref_q,
  output logic             en_q
);
  logic [TAG_W-1:0] ref_d;
  logic             en_d;

  always_comb begin
    ref_d = ref_q;
    en_d  = en_q;
    if (tag_wr_en) ref_d = tag_wr_data;
    if (en_wr)     en_d  = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      en_q  <= 1'b0;
    end else begin
      ref_q <= ref_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/tagchk_compare.sv
module tagchk_compare #(
  parameter int unsigned TAG_W = tagchk_pkg::TAG_W
) (
  input  logic                  test_req,
  input  logic                  mem_valid,
  input  tagchk_pkg::tag_mode_e mode,
  input  logic [TAG_W-1:0]      mem_tag,
  input  logic [TAG_W-1:0]      ref_tag,
  output logic                  fail
);
  logic [TAG_W-1:0] bit_diff;
  logic             tags_equal;

  for (genvar i = 0; i < TAG_W; i++) begin : g_bit
    assign bit_diff[i] = mem_tag[i] ^ ref_tag[i];
  end

  assign tags_equal = ~|bit_diff;

  always_comb begin
    fail = 1'b0;
    if (test_req && mem_valid) begin
      if (mode == tagchk_pkg::MODE_MATCH) fail = !tags_equal;
      else                                fail = tags_equal;
    end
  end
endmodule

// File: rtl/tagchk_fault.sv
module tagchk_fault #(
  parameter int unsigned TAG_W = tagchk_pkg::TAG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fail,
  input  logic [TAG_W-1:0]      fail_tag,
  input  tagchk_pkg::tag_mode_e fail_mode,
  input  logic                  clear,
  output logic                  fault_q,
  output logic [TAG_W-1:0]      cap_tag_q,
  output tagchk_pkg::tag_mode_e cap_mode_q
);
  logic                  fault_d;
  logic [TAG_W-1:0]      cap_tag_d;
  tagchk_pkg::tag_mode_e cap_mode_d;
  logic                  cap_en;

  always_comb begin
    fault_d    = fault_q;
    cap_tag_d  = cap_tag_q;
    cap_mode_d = cap_mode_q;
    cap_en     = fail && (!fault_q || clear);
    if (clear) fault_d = 1'b0;
    if (fail)  fault_d = 1'b1;
    if (cap_en) begin
      cap_tag_d  = fail_tag;
      cap_mode_d = fail_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q    <= 1'b0;
      cap_tag_q  <= '0;
      cap_mode_q <= tagchk_pkg::MODE_MATCH;
    end else begin
      fault_q    <= fault_d;
      cap_tag_q  <= cap_tag_d;
      cap_mode_q <= cap_mode_d;
    end
  end
endmodule

// File: rtl/tagchk_unit.sv
module tagchk_unit #(
  parameter int unsigned DATA_W = tagchk_pkg::DATA_W,
  parameter int unsigned TAG_W  = tagchk_pkg::TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_wr_en,
  input  logic [TAG_W-1:0]  tag_wr_data,
  input  logic              irq_en_wr,
  input  logic              irq_en_wdata,
  input  logic              test_req,
  input  logic              test_mode,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [TAG_W-1:0]  mem_tag,
  input  logic              fault_clear,
  output logic [DATA_W-1:0] data_out,
  output logic [TAG_W-1:0]  tag_out,
  output logic [TAG_W-1:0]  ref_tag,
  output logic              irq_enable,
  output logic              tag_fault,
  output logic [TAG_W-1:0]  cap_tag,
  output logic              cap_mode,
  output logic              irq
);
  tagchk_pkg::tag_mode_e mode_in;
  tagchk_pkg::tag_mode_e cap_mode_e;
  logic                  fail;

  assign mode_in  = tagchk_pkg::tag_mode_e'(test_mode);
  assign data_out = mem_data;
  assign tag_out  = mem_tag;
  assign cap_mode = cap_mode_e;
  assign irq      = tag_fault & irq_enable;

  tagchk_ref_reg #(.TAG_W(TAG_W)) u_ref (
    .clk         (clk),
    .rst_n       (rst_n),
    .tag_wr_en   (tag_wr_en),
    .tag_wr_data (tag_wr_data),
    .en_wr       (irq_en_wr),
    .en_wdata    (irq_en_wdata),
    .ref_q       (ref_tag),
    .en_q        (irq_enable)
  );

  tagchk_compare #(.TAG_W(TAG_W)) u_cmp (
    .test_req  (test_req),
    .mem_valid (mem_valid),
    .mode      (mode_in),
    .mem_tag   (mem_tag),
    .ref_tag   (ref_tag),
    .fail      (fail)
  );

  tagchk_fault #(.TAG_W(TAG_W)) u_flt (
    .clk        (clk),
    .rst_n      (rst_n),
    .fail       (fail),
    .fail_tag   (mem_tag),
    .fail_mode  (mode_in),
    .clear      (fault_clear),
    .fault_q    (tag_fault),
    .cap_tag_q  (cap_tag),
    .cap_mode_q (cap_mode_e)
  );
endmodule

// File: rtl/tagchk_checker.sv
module tagchk_checker #(
  parameter int unsigned TAG_W = tagchk_pkg::TAG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_req,
  input logic             test_mode,
  input logic             mem_valid,
  input logic [TAG_W-1:0] mem_tag,
  input logic [TAG_W-1:0] ref_tag,
  input logic             fault_clear,
  input logic             tag_fault,
  input logic [TAG_W-1:0] cap_tag,
  input logic             cap_mode,
  input logic             irq_enable,
  input logic             irq
);
  AST_MATCH_FAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && mem_valid && !test_mode && mem_tag != ref_tag) |=> tag_fault); // R2
  AST_DIFFER_FAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && mem_valid && test_mode && mem_tag == ref_tag) |=> tag_fault); // R3
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_fault && !fault_clear) |=> tag_fault); // R4
  AST_NO_FAULT_UNTESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_fault && !(test_req && mem_valid)) |=> !tag_fault); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |-> !irq); // R6
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_fault && !fault_clear) |=> ($stable(cap_tag) && $stable(cap_mode))); // R7
endmodule

bind tagchk_unit tagchk_checker #(.TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .test_req    (test_req),
  .test_mode   (test_mode),
  .mem_valid   (mem_valid),
  .mem_tag     (mem_tag),
  .ref_tag     (ref_tag),
  .fault_clear (fault_clear),
  .tag_fault   (tag_fault),
  .cap_tag     (cap_tag),
  .cap_mode    (cap_mode),
  .irq_enable  (irq_enable),
  .irq         (irq)
);

// File: tb/tagchk_unit_bench.sv
module tagchk_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tag_wr_en, irq_en_wr, irq_en_wdata;
  logic [2:0]  tag_wr_data, mem_tag;
  logic        test_req, test_mode, mem_valid, fault_clear;
  logic [23:0] mem_data;
  logic [23:0] data_out;
  logic [2:0]  tag_out, ref_tag, cap_tag;
  logic        irq_enable, tag_fault, cap_mode, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [2:0] m_ref, m_cap_tag;
  logic       m_en, m_fault, m_cap_mode;

  always #4 clk = ~clk;

  tagchk_unit u_tagchk_unit (
    .clk(clk), .rst_n(rst_n), .tag_wr_en(tag_wr_en), .tag_wr_data(tag_wr_data),
    .irq_en_wr(irq_en_wr), .irq_en_wdata(irq_en_wdata), .test_req(test_req),
    .test_mode(test_mode), .mem_valid(mem_valid), .mem_data(mem_data),
    .mem_tag(mem_tag), .fault_clear(fault_clear), .data_out(data_out),
    .tag_out(tag_out), .ref_tag(ref_tag), .irq_enable(irq_enable),
    .tag_fault(tag_fault), .cap_tag(cap_tag), .cap_mode(cap_mode), .irq(irq)
  );

  function automatic logic exp_fail(logic req, logic vld, logic md,
                                    logic [2:0] t, logic [2:0] r);
    if (!(req && vld)) return 1'b0;
    return md ? (t == r) : (t != r);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    tag_wr_en = 0; tag_wr_data = 0; irq_en_wr = 0; irq_en_wdata = 0;
    test_req = 0; test_mode = 0; mem_valid = 0; mem_data = 0;
    mem_tag = 0; fault_clear = 0;
  endtask

  task automatic check_state(string req);
    chk({req, " ref_tag"}, 32'(ref_tag), 32'(m_ref));
    chk({req, " irq_enable"}, 32'(irq_enable), 32'(m_en));
    chk({req, " tag_fault"}, 32'(tag_fault), 32'(m_fault));
    chk({req, " cap_tag"}, 32'(cap_tag), 32'(m_cap_tag));
    chk({req, " cap_mode"}, 32'(cap_mode), 32'(m_cap_mode));
    chk("R6 irq", 32'(irq), 32'(m_fault & m_en));
  endtask

  // Inputs are set at the negative edge; this applies one clock edge.
  task automatic step(string req);
    logic f;
    #1;
    chk("R1 data_out", 32'(data_out), 32'(mem_data));
    chk("R1 tag_out", 32'(tag_out), 32'(mem_tag));
    f = exp_fail(test_req, mem_valid, test_mode, mem_tag, m_ref);
    @(posedge clk);
    if (f && (!m_fault || fault_clear)) begin
      m_cap_tag = mem_tag; m_cap_mode = test_mode;
    end
    m_fault = f | (m_fault & ~fault_clear);
    if (tag_wr_en) m_ref = tag_wr_data;
    if (irq_en_wr) m_en = irq_en_wdata;
    @(negedge clk);
    check_state(req);
    idle();
  endtask

  task automatic test(logic md, logic [2:0] t);
    test_req = 1; mem_valid = 1; test_mode = md; mem_tag = t;
    mem_data = $urandom;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    rst_n = 0;
    m_ref = 0; m_en = 0; m_fault = 0; m_cap_tag = 0; m_cap_mode = 0;
    repeat (3) @(negedge clk);
    check_state("R9 reset");
    rst_n = 1;
    @(negedge clk);

    // R5: tests that would fail but are not requested or not valid
    test(1'b0, 3'd5); test_req = 0; step("R5 no request");
    test(1'b1, 3'd0); mem_valid = 0; step("R5 not valid");

    // R8: load reference 3, same-cycle match test against old 0 passes
    tag_wr_en = 1; tag_wr_data = 3'd3; test(1'b0, 3'd0); step("R8 old ref used");
    test(1'b0, 3'd3); step("R8 new ref active");

    // R6: enable interrupts, R2 equal-mode failure
    irq_en_wr = 1; irq_en_wdata = 1; step("R6 enable");
    test(1'b0, 3'd6); step("R2 match fail");
    // R7: second failure does not overwrite capture
    test(1'b1, 3'd3); step("R7 capture held");
    step("R4 sticky");
    irq_en_wr = 1; irq_en_wdata = 0; step("R6 masked");
    fault_clear = 1; step("R4 clear");
    // R3 differ-mode failure
    test(1'b1, 3'd3); step("R3 differ fail");
    // R10 clear collides with a new failure
    fault_clear = 1; test(1'b0, 3'd1); step("R10 set wins");
    fault_clear = 1; step("R4 clear again");

    // Random mixture, R1-style passthrough checked on every step
    for (int i = 0; i < 400; i++) begin
      tag_wr_en = ($urandom % 8) == 0; tag_wr_data = $urandom;
      irq_en_wr = ($urandom % 6) == 0; irq_en_wdata = $urandom;
      test_req = $urandom; mem_valid = $urandom; test_mode = $urandom;
      mem_tag = ($urandom % 2) ? m_ref : 3'($urandom);
      mem_data = $urandom;
      fault_clear = ($urandom % 5) == 0;
      step("R2/R3/R7 random");
    end

    rst_n = 0; #1;
    m_ref = 0; m_en = 0; m_fault = 0; m_cap_tag = 0; m_cap_mode = 0;
    check_state("R9 async reset");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule